// File: doc/BRIEF.md
# Coprocessor Status and Semaphore Register File

This block is a small control-register file next to a vector coprocessor. An agent reaches it through a single port that carries a register index, a write strobe, a read strobe and a 32-bit data word. The port exposes a status register, a hardware semaphore and two DMA length registers.

The status register is never written directly. Each write is a command word. Most flags have a clear bit and a set bit in that word: set alone raises the flag, clear alone lowers it, and both or neither leave it as it was. The flags handled this way are halt, single-step, interrupt-on-break and eight general signal bits. The same pair rule drives a level interrupt request line that has no bit in the status word. The broke flag can be lowered by a write, but only a break event input can raise it.

The semaphore gives two agents test-and-set locking. A read returns the current value and takes the lock if it was free. Any write releases the lock. The length registers read back a fixed completion value once a DMA transfer finishes. A one-cycle flag-check pulse tells the processor that a status write has left it halted or has left the interrupt line raised.

Top module: `cop_ctl_regs`

## Requirements
- R1: A status write updates each of halt, single-step, interrupt-on-break and signal i (i = 0..7) from a command pair. The clear and set bits are: halt 0/1, single-step 5/6, interrupt-on-break 7/8, signal i 9+2i/10+2i. Set alone gives 1, clear alone gives 0, and both or neither leave the flag unchanged. No other access changes these flags.
- R2: The interrupt request line follows the same pair rule, with its clear bit at 3 and its set bit at 4. It has no bit in the status word.
- R3: The broke flag is cleared by a status write with bit 2 set, and no write can set it. The break event input sets it. If a clear and a break event come in the same cycle, the event wins.
- R4: The status register is at index 4. A read returns halt at bit 0, broke at bit 1, single-step at bit 5, interrupt-on-break at bit 6 and signal i at bit 7+i. All other bits read 0. Reading the status register has no side effect.
- R5: The semaphore is at index 7. A read returns its current value. If that value was 0, the semaphore holds 1 after the read cycle.
- R6: Any write to index 7 clears the semaphore to 0, whatever the data. If a write and a read of index 7 come in the same cycle, the write wins, and the read returns the value held before that cycle.
- R7: The DMA read length register is at index 2 and the DMA write length register is at index 3. Each is writable with a full word. After a matching DMA-done pulse, each reads 0x00000FF8. A done pulse in the same cycle as a write wins.
- R8: The flag-check output pulses high for exactly the cycle that follows a status write, and only if halt or the interrupt line is set after that write.
- R9: After reset, every register reads 0, and halt, the interrupt line and flag-check are low. An unmapped index reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write strobe for the register port |
| cfg_rd_en | input | 1 | Read strobe (triggers the semaphore side effect) |
| cfg_idx | input | 4 | Register index |
| cfg_wdata | input | 32 | Write data or command word |
| cfg_rdata | output | 32 | Read data for cfg_idx, showing the value before this cycle's edge |
| brk_event | input | 1 | Break event; sets the broke flag |
| dma_rd_done | input | 1 | DMA read transfer finished |
| dma_wr_done | input | 1 | DMA write transfer finished |
| halt_flag | output | 1 | Current halt flag |
| irq_req | output | 1 | Level interrupt request |
| flag_check | output | 1 | One-cycle pulse after a status write that leaves halt or the interrupt line set |

## Verification
The hardest case to reach is a semaphore read and a semaphore write in the same cycle while the lock is taken. The read must return 1, and the lock must end up free rather than retaken. Directed steps place both strobes on one edge. The next read must then return 0 and take the lock again. Random traffic over the mapped indices also produces this case. Each flag is driven through all four command-pair combinations from both prior states, so the both-bits-means-hold rule is covered for every flag.

// File: rtl/cop_ctl_pkg.sv
package cop_ctl_pkg;

    localparam int DATA_W   = 32;
    localparam int IDX_W    = 4;
    localparam int NUM_SIG  = 8;
    localparam int NUM_PAIR = 3 + NUM_SIG;

    localparam logic [IDX_W-1:0] IDX_RDLEN  = IDX_W'(2);
    localparam logic [IDX_W-1:0] IDX_WRLEN  = IDX_W'(3);
    localparam logic [IDX_W-1:0] IDX_STATUS = IDX_W'(4);
    localparam logic [IDX_W-1:0] IDX_SEM    = IDX_W'(7);

    localparam logic [DATA_W-1:0] LEN_DONE = DATA_W'(32'h0000_0FF8);

    // status word positions
    localparam int ST_BROKE = 1;

    // command word positions without a generic pair
    localparam int CMD_CLR_BROKE = 2;
    localparam int CMD_CLR_IRQ   = 3;
    localparam int CMD_SET_IRQ   = 4;

    typedef enum logic [1:0] {
        PAIR_HOLD = 2'd0,
        PAIR_CLR  = 2'd1,
        PAIR_SET  = 2'd2
    } pair_act_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } reg_req_t;

    // pair k: 0 halt, 1 single-step, 2 interrupt-on-break, 3+i signal i
    function automatic int pair_clr_pos(input int k);
        case (k)
            0:       return 0;
            1:       return 5;
            2:       return 7;
            default: return 9 + 2 * (k - 3);
        endcase
    endfunction

    function automatic int pair_set_pos(input int k);
        return pair_clr_pos(k) + 1;
    endfunction

    function automatic int pair_st_pos(input int k);
        case (k)
            0:       return 0;
            1:       return 5;
            2:       return 6;
            default: return 7 + (k - 3);
        endcase
    endfunction

    function automatic pair_act_e decode_pair(input logic clr, input logic set);
        if (set && !clr)      return PAIR_SET;
        else if (clr && !set) return PAIR_CLR;
        else                  return PAIR_HOLD;
    endfunction

endpackage

// File: rtl/cop_pair_flag.sv
module cop_pair_flag
    import cop_ctl_pkg::*;
#(
    parameter int CLR_POS = 0,
    parameter int SET_POS = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_en,
    input  logic [DATA_W-1:0] cmd,
    output logic              q
);
    pair_act_e act;

    always_comb act = decode_pair(cmd[CLR_POS], cmd[SET_POS]);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (cmd_en) begin
            case (act)
                PAIR_SET: q <= 1'b1;
                PAIR_CLR: q <= 1'b0;
                default:  q <= q;
            endcase
        end
    end
endmodule

// File: rtl/cop_sem.sv
module cop_sem (
    input  logic clk,
    input  logic rst,
    input  logic take_req,
    input  logic release_req,
    output logic locked
);
    always_ff @(posedge clk) begin
        if (rst) begin
            locked <= 1'b0;
        end else if (release_req) begin
            locked <= 1'b0;
        end else if (take_req && !locked) begin
            locked <= 1'b1;
        end
    end
endmodule

// File: rtl/cop_len_reg.sv
module cop_len_reg
    import cop_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] len
);
    always_ff @(posedge clk) begin
        if (rst)        len <= '0;
        else if (done)  len <= LEN_DONE;
        else if (wr_en) len <= wdata;
    end
endmodule

// File: rtl/cop_ctl_regs.sv
module cop_ctl_regs
    import cop_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic              cfg_rd_en,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              brk_event,
    input  logic              dma_rd_done,
    input  logic              dma_wr_done,
    output logic              halt_flag,
    output logic              irq_req,
    output logic              flag_check
);
    reg_req_t req;
    logic st_wr, sem_wr, sem_rd, rdlen_wr, wrlen_wr;
    logic [NUM_PAIR-1:0] pair_q;
    logic broke_q;
    logic st_wr_d;
    logic sem_q;
    logic [DATA_W-1:0] rdlen_q, wrlen_q, status_word;

    always_comb begin
        req.wr   = cfg_wr_en;
        req.rd   = cfg_rd_en;
        req.idx  = cfg_idx;
        req.data = cfg_wdata;
    end

    always_comb begin
        st_wr    = req.wr && (req.idx == IDX_STATUS);
        sem_wr   = req.wr && (req.idx == IDX_SEM);
        sem_rd   = req.rd && (req.idx == IDX_SEM);
        rdlen_wr = req.wr && (req.idx == IDX_RDLEN);
        wrlen_wr = req.wr && (req.idx == IDX_WRLEN);
    end

    generate
        for (genvar k = 0; k < NUM_PAIR; k++) begin : g_pair
            cop_pair_flag #(
                .CLR_POS(pair_clr_pos(k)),
                .SET_POS(pair_set_pos(k))
            ) u_flag (
                .clk(clk), .rst(rst), .cmd_en(st_wr), .cmd(req.data), .q(pair_q[k])
            );
        end
    endgenerate

    cop_pair_flag #(
        .CLR_POS(CMD_CLR_IRQ),
        .SET_POS(CMD_SET_IRQ)
    ) u_irq (
        .clk(clk), .rst(rst), .cmd_en(st_wr), .cmd(req.data), .q(irq_req)
    );

    always_ff @(posedge clk) begin
        if (rst)                                  broke_q <= 1'b0;
        else if (brk_event)                       broke_q <= 1'b1;
        else if (st_wr && req.data[CMD_CLR_BROKE]) broke_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_wr_d <= 1'b0;
        else     st_wr_d <= st_wr;
    end

    cop_sem u_sem (
        .clk(clk), .rst(rst), .take_req(sem_rd), .release_req(sem_wr), .locked(sem_q)
    );

    cop_len_reg u_rdlen (
        .clk(clk), .rst(rst), .done(dma_rd_done), .wr_en(rdlen_wr),
        .wdata(req.data), .len(rdlen_q)
    );

    cop_len_reg u_wrlen (
        .clk(clk), .rst(rst), .done(dma_wr_done), .wr_en(wrlen_wr),
        .wdata(req.data), .len(wrlen_q)
    );

    always_comb begin
        status_word = '0;
        for (int k = 0; k < NUM_PAIR; k++) status_word[pair_st_pos(k)] = pair_q[k];
        status_word[ST_BROKE] = broke_q;
    end

    always_comb begin
        case (req.idx)
            IDX_STATUS: cfg_rdata = status_word;
            IDX_SEM:    cfg_rdata = {{(DATA_W-1){1'b0}}, sem_q};
            IDX_RDLEN:  cfg_rdata = rdlen_q;
            IDX_WRLEN:  cfg_rdata = wrlen_q;
            default:    cfg_rdata = '0;
        endcase
    end

    assign halt_flag  = pair_q[0];
    assign flag_check = st_wr_d && (pair_q[0] || irq_req);
endmodule

// File: rtl/cop_ctl_chk.sv
module cop_ctl_chk
    import cop_ctl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [IDX_W-1:0]  idx,
    input logic              brk,
    input logic              rd_done,
    input logic              halt,
    input logic              irq,
    input logic              fchk,
    input logic [DATA_W-1:0] stat,
    input logic              sem,
    input logic [DATA_W-1:0] rdlen
);
    p_halt_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && idx == IDX_STATUS) |=> $stable(halt));

    p_irq_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && idx == IDX_STATUS) |=> $stable(irq));

    p_broke_no_write_set_r3: assert property (@(posedge clk) disable iff (rst)
        !brk |=> !$rose(stat[ST_BROKE]));

    p_sem_take_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && idx == IDX_SEM && !wr_en && !sem) |=> sem);

    p_sem_release_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && idx == IDX_SEM) |=> !sem);

    p_len_done_r7: assert property (@(posedge clk) disable iff (rst)
        rd_done |=> (rdlen == LEN_DONE));

    p_check_source_r8: assert property (@(posedge clk) disable iff (rst)
        fchk |-> $past(wr_en && idx == IDX_STATUS));

    p_check_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        (fchk && !(wr_en && idx == IDX_STATUS)) |=> !fchk);
endmodule

bind cop_ctl_regs cop_ctl_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .rd_en(cfg_rd_en), .idx(cfg_idx),
    .brk(brk_event), .rd_done(dma_rd_done), .halt(halt_flag), .irq(irq_req),
    .fchk(flag_check), .stat(status_word), .sem(sem_q), .rdlen(rdlen_q)
);

// File: tb/tb_cop_ctl_regs.sv
`timescale 1ns/1ps
module tb_cop_ctl_regs;
    logic clk = 0, rst = 1;
    logic wr = 0, rd = 0, be = 0, drd = 0, dwr = 0;
    logic [3:0]  idx = 0;
    logic [31:0] wd = 0;
    logic [31:0] rdata;
    logic halt, irq, fchk;
    int total = 0, bad = 0;
    bit finished = 0;

    // bench model
    logic [10:0] m_pair;
    logic m_broke, m_irq, m_sem, m_chk;
    logic [31:0] m_rdl, m_wrl;

    always #10 clk = ~clk;

    cop_ctl_regs dut (
        .clk(clk), .rst(rst), .cfg_wr_en(wr), .cfg_rd_en(rd), .cfg_idx(idx),
        .cfg_wdata(wd), .cfg_rdata(rdata), .brk_event(be), .dma_rd_done(drd),
        .dma_wr_done(dwr), .halt_flag(halt), .irq_req(irq), .flag_check(fchk)
    );

    function automatic int clr_bit(input int k);
        if (k == 0) return 0;
        if (k == 1) return 5;
        if (k == 2) return 7;
        return 9 + 2 * (k - 3);
    endfunction

    function automatic int st_bit(input int k);
        if (k == 0) return 0;
        if (k == 1) return 5;
        if (k == 2) return 6;
        return 4 + k;
    endfunction

    function automatic logic pair_next(input logic old, input logic c, input logic s);
        if (s && !c) return 1'b1;
        if (c && !s) return 1'b0;
        return old;
    endfunction

    function automatic logic [31:0] exp_status();
        logic [31:0] v = '0;
        for (int k = 0; k < 11; k++) v[st_bit(k)] = m_pair[k];
        v[1] = m_broke;
        return v;
    endfunction

    function automatic logic [31:0] exp_read(input logic [3:0] i);
        case (i)
            4'd4: return exp_status();
            4'd7: return {31'b0, m_sem};
            4'd2: return m_rdl;
            4'd3: return m_wrl;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one access cycle; checks read data then model state after the edge
    task automatic op(input logic w, input logic r, input logic [3:0] i, input logic [31:0] d,
                      input logic b, input logic dr, input logic dw, input string tag);
        logic [31:0] exp_rd;
        wr = w; rd = r; idx = i; wd = d; be = b; drd = dr; dwr = dw;
        #1;
        exp_rd = exp_read(i);
        check({tag, " read R4 R5 R9"}, rdata, exp_rd);
        @(negedge clk);
        wr = 0; rd = 0; be = 0; drd = 0; dwr = 0;
        if (w && i == 4'd4) begin
            for (int k = 0; k < 11; k++)
                m_pair[k] = pair_next(m_pair[k], d[clr_bit(k)], d[clr_bit(k) + 1]);
            m_irq = pair_next(m_irq, d[3], d[4]);
            if (d[2]) m_broke = 1'b0;
        end
        if (b) m_broke = 1'b1;
        if (w && i == 4'd7) m_sem = 1'b0;
        else if (r && i == 4'd7 && !m_sem) m_sem = 1'b1;
        if (dr) m_rdl = 32'hFF8; else if (w && i == 4'd2) m_rdl = d;
        if (dw) m_wrl = 32'hFF8; else if (w && i == 4'd3) m_wrl = d;
        m_chk = w && i == 4'd4 && (m_pair[0] || m_irq);
        check({tag, " halt R1"}, {31'b0, halt}, {31'b0, m_pair[0]});
        check({tag, " irq R2"}, {31'b0, irq}, {31'b0, m_irq});
        check({tag, " flag_check R8"}, {31'b0, fchk}, {31'b0, m_chk});
    endtask

    task automatic peek(input logic [3:0] i, input string tag);
        idx = i; #1;
        check(tag, rdata, exp_read(i));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_pair = '0; m_broke = 0; m_irq = 0; m_sem = 0; m_chk = 0; m_rdl = 0; m_wrl = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R9 reset state
        peek(4'd4, "reset status R9");
        peek(4'd2, "reset rdlen R9");
        peek(4'd3, "reset wrlen R9");
        peek(4'd9, "unmapped R9");
        check("reset halt R9", {31'b0, halt}, 32'h0);
        check("reset irq R9", {31'b0, irq}, 32'h0);
        check("reset check R9", {31'b0, fchk}, 32'h0);
        peek(4'd7, "reset sem R9");

        // R1 every pair combination from both prior states
        for (int k = 0; k < 11; k++)
            for (int pre = 0; pre < 2; pre++)
                for (int c = 0; c < 4; c++) begin
                    op(1, 0, 4'd4, 32'h1 << (clr_bit(k) + pre), 0, 0, 0, "R1 preset");
                    op(1, 0, 4'd4, (32'(c[0]) << clr_bit(k)) | (32'(c[1]) << (clr_bit(k) + 1)),
                       0, 0, 0, "R1 combo");
                    peek(4'd4, "R1 status after combo");
                end
        // R2 interrupt line
        for (int pre = 0; pre < 2; pre++)
            for (int c = 0; c < 4; c++) begin
                op(1, 0, 4'd4, 32'h1 << (3 + pre), 0, 0, 0, "R2 preset");
                op(1, 0, 4'd4, (32'(c[0]) << 3) | (32'(c[1]) << 4), 0, 0, 0, "R2 combo");
            end
        // R3 broke flag
        op(0, 0, 4'd0, 0, 1, 0, 0, "R3 event");
        peek(4'd4, "R3 broke set by event");
        op(1, 0, 4'd4, 32'hFFFF_FFFB, 0, 0, 0, "R3 write without clear");
        peek(4'd4, "R3 broke kept");
        op(1, 0, 4'd4, 32'h4, 0, 0, 0, "R3 clear");
        peek(4'd4, "R3 broke cleared");
        op(1, 0, 4'd4, 32'hFFFF_FFFB, 0, 0, 0, "R3 no set by write");
        peek(4'd4, "R3 broke stays low");
        op(1, 0, 4'd4, 32'h4, 1, 0, 0, "R3 event beats clear");
        peek(4'd4, "R3 broke after race");
        // R5 R6 semaphore
        op(1, 0, 4'd7, 32'h0, 0, 0, 0, "R6 release");
        op(0, 1, 4'd7, 0, 0, 0, 0, "R5 take free");
        op(0, 1, 4'd7, 0, 0, 0, 0, "R5 read taken");
        op(1, 0, 4'd7, 32'h5A, 0, 0, 0, "R6 write any value");
        op(0, 1, 4'd7, 0, 0, 0, 0, "R5 retake");
        op(1, 1, 4'd7, 32'hFFFF_FFFF, 0, 0, 0, "R6 read+write same cycle");
        peek(4'd7, "R6 write wins");
        op(1, 1, 4'd7, 32'h1, 0, 0, 0, "R6 read+write when free");
        peek(4'd7, "R6 still free");
        // R7 length registers
        op(1, 0, 4'd2, 32'h1234_5678, 0, 0, 0, "R7 write rdlen");
        peek(4'd2, "R7 rdlen readback");
        op(0, 0, 4'd0, 0, 0, 1, 0, "R7 read done");
        peek(4'd2, "R7 rdlen done");
        op(1, 0, 4'd3, 32'hCAFE, 0, 0, 1, "R7 done beats write");
        peek(4'd3, "R7 wrlen done");
        // random traffic
        void'($urandom(32'd4242));
        for (int n = 0; n < 600; n++) begin
            logic [3:0] ri;
            case ($urandom % 6)
                0: ri = 4'd2; 1: ri = 4'd3; 2, 3: ri = 4'd4; 4: ri = 4'd7; default: ri = 4'($urandom);
            endcase
            op(1'($urandom), 1'($urandom), ri, $urandom, ($urandom % 8) == 0,
               ($urandom % 10) == 0, ($urandom % 10) == 0, "random R1 R3 R5 R6 R7");
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule